// File: doc/BRIEF.md
# Twelve-Hour Alarm Clock Core

This block keeps the time of day in 12-hour form with a morning/afternoon flag. It also holds an alarm setting that is stored separately from the running time. A single fast system clock drives every register. Two free-running dividers produce single-cycle enables: one marks whole seconds and the other marks half seconds. No derived clock exists anywhere in the block.

Four debounced controls steer the block. A set pulse switches between running and setting the time. A view pulse switches between running and editing the alarm. Two held-level buttons step the hour and the minute fields. While a field is being edited, a held button moves it once per half second. The display outputs show the running time, or the alarm setting while the alarm is being edited. The buzzer output is raised while the running time matches the alarm.

Top module: `alarm_clock12`

## Requirements
- R1: A synchronous active-high reset loads the running time 12:00:00 AM and the alarm 12:00 AM, and selects run mode (`show_alarm` = 0). The morning flag encodes AM as 0 and PM as 1.
- R2: In run mode and in alarm-edit mode, seconds advance once every `SEC_DIV` cycles. The divider restarts at reset, so the first advance lands on the `SEC_DIV`-th edge after reset is released. Seconds stay within 0..59.
- R3: When seconds roll from 59 to 0, minutes advance. When minutes roll from 59 to 0, the hour advances.
- R4: An hour step from 11 to 12 inverts the AM/PM flag. A step from 12 to 1 wraps without inverting it. Hours stay within 1..12.
- R5: `set_tgl` moves run mode to set mode and set mode back to run mode. `alm_tgl` moves run mode to alarm-edit mode and back again. A toggle for the other non-run mode is ignored. If both arrive in run mode, set mode wins.
- R6: In set mode the running time does not advance on second enables. On each half-second enable a held `hr_btn` steps the hour (following R4), and a held `min_btn` steps the minute from 59 to 0 without carrying into the hour.
- R7: In alarm-edit mode the displays show the alarm hour, minute and AM/PM flag, seconds show 0, and `show_alarm` is 1. Held buttons step the alarm fields on half-second enables, following the rules of R6. The running time keeps advancing.
- R8: `buzz` is 1 exactly when the mode is run and the running hour, minute and AM/PM flag equal those of the alarm.
- R9: In run mode `hr_btn` and `min_btn` have no effect on either time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| set_tgl | input | 1 | One-cycle pulse toggling set mode |
| alm_tgl | input | 1 | One-cycle pulse toggling alarm-edit mode |
| hr_btn | input | 1 | Hour step button, held level |
| min_btn | input | 1 | Minute step button, held level |
| disp_hr | output | 4 | Hour shown, 1..12 |
| disp_min | output | 6 | Minute shown, 0..59 |
| disp_sec | output | 6 | Second shown, 0..59 (0 while the alarm is shown) |
| disp_pm | output | 1 | AM/PM flag shown, 1 = PM |
| show_alarm | output | 1 | 1 while the alarm setting is on show |
| buzz | output | 1 | Alarm match indication |

## Verification
The block is first left idle to observe the second cadence. The step buttons are then held in run mode, which must have no effect. Long holds in set mode move the hour through the 12→1 wrap and the minute through the 59→0 wrap without a carry. Ignored and simultaneous mode toggles separate the priority rule from a plain toggle. Setting the alarm to 12 PM and running the time across 11:59 AM tests the carry chain, the AM/PM inversion and the buzzer together. Entering set mode afterwards shows that the buzzer is masked.

// File: rtl/clkal_pkg.sv
package clkal_pkg;
  localparam int HR_W = 4;
  localparam int MS_W = 6;

  typedef enum logic [1:0] {
    MODE_RUN = 2'd0,
    MODE_SET = 2'd1,
    MODE_ALM = 2'd2
  } clk_mode_e;

  function automatic logic [HR_W-1:0] hour_step(input logic [HR_W-1:0] h);
    return (h == HR_W'(12)) ? HR_W'(1) : h + HR_W'(1);
  endfunction

  function automatic logic hour_flips_pm(input logic [HR_W-1:0] h);
    return h == HR_W'(11);
  endfunction

  function automatic logic [MS_W-1:0] sixty_step(input logic [MS_W-1:0] v);
    return (v == MS_W'(59)) ? '0 : v + MS_W'(1);
  endfunction
endpackage

// File: rtl/cadence_div.sv
module cadence_div #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import clkal_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_tgl,
  input  logic      alm_tgl,
  output clk_mode_e mode
);
  clk_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (set_tgl && mode_q != MODE_ALM)
      mode_d = (mode_q == MODE_SET) ? MODE_RUN : MODE_SET;
    else if (alm_tgl && mode_q != MODE_SET)
      mode_d = (mode_q == MODE_ALM) ? MODE_RUN : MODE_ALM;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R5
  mode_path_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SET) |=> (mode_q != MODE_ALM));
endmodule

// File: rtl/time_core.sv
module time_core
  import clkal_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sec_tick,
  input  logic            half_tick,
  input  clk_mode_e       mode,
  input  logic            hr_btn,
  input  logic            min_btn,
  output logic [HR_W-1:0] hr,
  output logic [MS_W-1:0] mn,
  output logic [MS_W-1:0] sc,
  output logic            pm
);
  logic [HR_W-1:0] hr_q;
  logic [MS_W-1:0] mn_q, sc_q;
  logic            pm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_q <= HR_W'(12);
      mn_q <= '0;
      sc_q <= '0;
      pm_q <= 1'b0;
    end else if (mode == MODE_SET) begin
      if (half_tick && hr_btn) begin
        hr_q <= hour_step(hr_q);
        if (hour_flips_pm(hr_q)) pm_q <= ~pm_q;
      end
      if (half_tick && min_btn) mn_q <= sixty_step(mn_q);
    end else if (sec_tick) begin
      sc_q <= sixty_step(sc_q);
      if (sc_q == MS_W'(59)) begin
        mn_q <= sixty_step(mn_q);
        if (mn_q == MS_W'(59)) begin
          hr_q <= hour_step(hr_q);
          if (hour_flips_pm(hr_q)) pm_q <= ~pm_q;
        end
      end
    end
  end

  assign hr = hr_q;
  assign mn = mn_q;
  assign sc = sc_q;
  assign pm = pm_q;

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    sc_q <= MS_W'(59));
  // R4
  hr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_q >= HR_W'(1)) && (hr_q <= HR_W'(12)));
  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_q != $past(pm_q)) |-> (hr_q == HR_W'(12)));
endmodule

// File: rtl/alarm_store.sv
module alarm_store
  import clkal_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            half_tick,
  input  clk_mode_e       mode,
  input  logic            hr_btn,
  input  logic            min_btn,
  output logic [HR_W-1:0] a_hr,
  output logic [MS_W-1:0] a_mn,
  output logic            a_pm
);
  logic [HR_W-1:0] hr_q;
  logic [MS_W-1:0] mn_q;
  logic            pm_q;
  logic            edit;

  assign edit = (mode == MODE_ALM) && half_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_q <= HR_W'(12);
      mn_q <= '0;
      pm_q <= 1'b0;
    end else begin
      if (edit && hr_btn) begin
        hr_q <= hour_step(hr_q);
        if (hour_flips_pm(hr_q)) pm_q <= ~pm_q;
      end
      if (edit && min_btn) mn_q <= sixty_step(mn_q);
    end
  end

  assign a_hr = hr_q;
  assign a_mn = mn_q;
  assign a_pm = pm_q;

  // R7
  alarm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_ALM) |=> ($stable(hr_q) && $stable(mn_q) && $stable(pm_q)));
endmodule

// File: rtl/alarm_clock12.sv
module alarm_clock12
  import clkal_pkg::*;
#(
  parameter int SEC_DIV  = 50_000_000,
  parameter int HALF_DIV = 25_000_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_tgl,
  input  logic            alm_tgl,
  input  logic            hr_btn,
  input  logic            min_btn,
  output logic [HR_W-1:0] disp_hr,
  output logic [MS_W-1:0] disp_min,
  output logic [MS_W-1:0] disp_sec,
  output logic            disp_pm,
  output logic            show_alarm,
  output logic            buzz
);
  localparam int N_DIV = 2;
  localparam int DIVS [N_DIV] = '{SEC_DIV, HALF_DIV};

  logic [N_DIV-1:0] ticks;
  logic             sec_tick, half_tick;
  clk_mode_e        mode;
  logic [HR_W-1:0]  t_hr, a_hr;
  logic [MS_W-1:0]  t_mn, t_sc, a_mn;
  logic             t_pm, a_pm;

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    cadence_div #(.DIV(DIVS[g])) div_i (
      .clk(clk), .rst(rst), .tick(ticks[g])
    );
  end

  assign sec_tick  = ticks[0];
  assign half_tick = ticks[1];

  mode_ctrl mode_i (
    .clk(clk), .rst(rst), .set_tgl(set_tgl), .alm_tgl(alm_tgl), .mode(mode)
  );

  time_core time_i (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .half_tick(half_tick),
    .mode(mode), .hr_btn(hr_btn), .min_btn(min_btn),
    .hr(t_hr), .mn(t_mn), .sc(t_sc), .pm(t_pm)
  );

  alarm_store alarm_i (
    .clk(clk), .rst(rst), .half_tick(half_tick), .mode(mode),
    .hr_btn(hr_btn), .min_btn(min_btn),
    .a_hr(a_hr), .a_mn(a_mn), .a_pm(a_pm)
  );

  always_comb begin
    show_alarm = (mode == MODE_ALM);
    if (show_alarm) begin
      disp_hr  = a_hr;
      disp_min = a_mn;
      disp_sec = '0;
      disp_pm  = a_pm;
    end else begin
      disp_hr  = t_hr;
      disp_min = t_mn;
      disp_sec = t_sc;
      disp_pm  = t_pm;
    end
    buzz = (mode == MODE_RUN) && (t_hr == a_hr) && (t_mn == a_mn) && (t_pm == a_pm);
  end

  // R8
  buzz_mask_chk: assert property (@(posedge clk) disable iff (rst)
    buzz |-> (mode == MODE_RUN));
  // R6
  set_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SET) |=> $stable(t_sc));
endmodule

// File: tb/alarm_clock12_tb_top.sv
module alarm_clock12_tb_top;
  localparam int SD = 10;
  localparam int HD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_tgl = 1'b0, alm_tgl = 1'b0, hr_btn = 1'b0, min_btn = 1'b0;
  logic [3:0] disp_hr;
  logic [5:0] disp_min, disp_sec;
  logic disp_pm, show_alarm, buzz;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alarm_clock12 #(.SEC_DIV(SD), .HALF_DIV(HD)) dut_i (
    .clk(clk), .rst(rst), .set_tgl(set_tgl), .alm_tgl(alm_tgl),
    .hr_btn(hr_btn), .min_btn(min_btn), .disp_hr(disp_hr),
    .disp_min(disp_min), .disp_sec(disp_sec), .disp_pm(disp_pm),
    .show_alarm(show_alarm), .buzz(buzz)
  );

  typedef struct {int hr; int mn; int sc; int pm; int sa; int bz;} exp_t;
  exp_t sbq[$];

  // reference state, derived from the requirements; mode 0 run, 1 set, 2 alarm edit
  int m_sc = 0, m_hc = 0, m_mode = 0;
  int th = 12, tm = 0, ts = 0, tp = 0, ah = 12, am = 0, ap = 0;

  function automatic int nh(int h); return (h == 12) ? 1 : h + 1; endfunction
  function automatic int n60(int v); return (v == 59) ? 0 : v + 1; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(logic r, logic s, logic a, logic h, logic m);
    bit st, ht;
    exp_t e;
    if (r) begin
      m_sc = 0; m_hc = 0; m_mode = 0;
      th = 12; tm = 0; ts = 0; tp = 0; ah = 12; am = 0; ap = 0;
    end else begin
      st = (m_sc == SD - 1);
      ht = (m_hc == HD - 1);
      m_sc = st ? 0 : m_sc + 1;
      m_hc = ht ? 0 : m_hc + 1;
      if (m_mode == 1) begin
        if (ht && h) begin if (th == 11) tp ^= 1; th = nh(th); end
        if (ht && m) tm = n60(tm);
      end else if (st) begin
        if (ts == 59) begin
          if (tm == 59) begin if (th == 11) tp ^= 1; th = nh(th); end
          tm = n60(tm);
        end
        ts = n60(ts);
      end
      if (m_mode == 2 && ht) begin
        if (h) begin if (ah == 11) ap ^= 1; ah = nh(ah); end
        if (m) am = n60(am);
      end
      if (s && m_mode != 2) m_mode = (m_mode == 1) ? 0 : 1;
      else if (a && m_mode != 1) m_mode = (m_mode == 2) ? 0 : 2;
    end
    if (m_mode == 2) e = '{ah, am, 0, ap, 1, 0};
    else e = '{th, tm, ts, tp, 0, int'(m_mode == 0 && th == ah && tm == am && tp == ap)};
    sbq.push_back(e);
  endtask

  // driver: one clock of stimulus, expectation pushed after the edge
  task automatic step(logic r, logic s, logic a, logic h, logic m);
    rst = r; set_tgl = s; alm_tgl = a; hr_btn = h; min_btn = m;
    @(posedge clk);
    model_edge(r, s, a, h, m);
    @(negedge clk);
  endtask

  task automatic idle(int n, logic h = 1'b0, logic m = 1'b0);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, h, m);
  endtask

  // monitor: pops one expectation per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk("R2 sec", int'(disp_sec), e.sc);
        chk("R3 min", int'(disp_min), e.mn);
        chk("R4 hour", int'(disp_hr), e.hr);
        chk("R4 pm", int'(disp_pm), e.pm);
        chk("R5 show_alarm", int'(show_alarm), e.sa);
        chk("R8 buzz", int'(buzz), e.bz);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sec_hold;
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    // R1 reset values
    chk("R1 hour", int'(disp_hr), 12);
    chk("R1 min", int'(disp_min), 0);
    chk("R1 sec", int'(disp_sec), 0);
    chk("R1 pm", int'(disp_pm), 0);
    chk("R1 show_alarm", int'(show_alarm), 0);
    chk("R8 buzz at reset match", int'(buzz), 1);
    // R2 first second lands on edge SD after release
    idle(SD - 1);
    chk("R2 sec before tick", int'(disp_sec), 0);
    idle(1);
    chk("R2 sec after tick", int'(disp_sec), 1);
    // R9 buttons ignored in run mode
    idle(30, 1'b1, 1'b1);
    chk("R9 hour unchanged", int'(disp_hr), 12);
    chk("R9 min unchanged", int'(disp_min), 0);
    // R6 set mode
    step(0, 1, 0, 0, 0);
    sec_hold = int'(disp_sec);
    idle(11 * HD, 1'b1, 1'b0);
    chk("R6 hour stepped", int'(disp_hr), 11);
    chk("R4 12 to 1 no flip", int'(disp_pm), 0);
    idle(60 * HD, 1'b0, 1'b1);
    chk("R6 min wrap", int'(disp_min), 0);
    chk("R6 no carry", int'(disp_hr), 11);
    idle(59 * HD, 1'b0, 1'b1);
    chk("R6 min 59", int'(disp_min), 59);
    chk("R6 sec frozen", int'(disp_sec), sec_hold);
    step(0, 0, 1, 0, 0);
    chk("R5 alarm toggle ignored in set", int'(show_alarm), 0);
    step(0, 1, 0, 0, 0);
    // R7 alarm edit
    step(0, 0, 1, 0, 0);
    chk("R7 show_alarm", int'(show_alarm), 1);
    chk("R7 alarm hour", int'(disp_hr), 12);
    chk("R7 sec zero", int'(disp_sec), 0);
    idle(12 * HD, 1'b1, 1'b0);
    chk("R7 alarm hour", int'(disp_hr), 12);
    chk("R4 alarm pm flip", int'(disp_pm), 1);
    step(0, 1, 0, 0, 0);
    chk("R5 set toggle ignored in alarm", int'(show_alarm), 1);
    step(0, 0, 1, 0, 0);
    chk("R5 back to run", int'(show_alarm), 0);
    chk("R8 no match", int'(buzz), 0);
    for (int i = 0; i < 800 && disp_hr != 4'd12; i++) idle(1);
    chk("R3 carry to hour", int'(disp_hr), 12);
    chk("R3 min zero", int'(disp_min), 0);
    chk("R4 pm flip 11 to 12", int'(disp_pm), 1);
    chk("R8 match", int'(buzz), 1);
    idle(SD);
    chk("R8 match holds", int'(buzz), 1);
    step(0, 1, 0, 0, 0);
    chk("R8 masked in set", int'(buzz), 0);
    idle(HD, 1'b1, 1'b0);
    chk("R4 12 to 1", int'(disp_hr), 1);
    chk("R4 pm kept", int'(disp_pm), 1);
    step(0, 1, 0, 0, 0);
    // R5 both toggles in run: set wins, time frozen, minute editable
    step(0, 1, 1, 0, 0);
    chk("R5 both gives set", int'(show_alarm), 0);
    sec_hold = int'(disp_sec);
    idle(SD + 1);
    chk("R5 set mode frozen", int'(disp_sec), sec_hold);
    idle(5);
    while (sbq.size() > 0) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule